// File: doc/BRIEF.md
# One-Time-Programmable Fuse Sequencer

This block sits between a 32-bit register bus and a one-time-programmable fuse array. Software selects a fuse word by bank and word index, loads cycle counts for the relax and strobe phases, and then starts either a sense, which copies a word out of the array into a read-data register, or a program, which burns a 32-bit value into the selected word. While an operation runs, a busy flag is raised. Any misuse sets a sticky error flag: a program with no unlock key, a start while busy, or a bank outside the populated range.

Each operation runs on a single cycle counter. An opening relax interval comes first, then the strobe, during which the array is driven, then a closing relax interval. The strobe counts in the timing register already include both relax intervals, so an operation keeps the block busy for exactly strobe count + 1 cycles. Programming only sets bits, so a programmed word holds the OR of its old contents and the new value. The unlock key is erased when a program finishes, so every program needs a fresh unlock.

Top module: `otp_fuse_ctl`

## Requirements
- R1: After reset every register reads zero and busy is low. The byte offsets are: control 0x00, control-set 0x04, control-clear 0x08, timing 0x0C, read-control 0x10, read-data 0x14, program-data 0x18.
- R2: The timing register holds the program-strobe count in bits 11:0, the relax count in bits 15:12 and the read-strobe count in bits 21:16, and reads back as written. A sense keeps busy high for read-strobe + 1 cycles and a program keeps it high for program-strobe + 1 cycles.
- R3: Control bits 31:16 hold the unlock key, bit 9 the error flag, bit 8 the read-only busy flag, and bits 6:0 the address, with the bank in bits 6:3 and the word in bits 2:0. A write to control-set ORs the written key and address bits in, and a write to control-clear clears them. A 1 in bit 9 of a control-clear write clears the error flag, and a 0 there leaves it unchanged. Key and address writes are ignored while busy.
- R4: Writing 1 to bit 0 of read-control starts a sense of the addressed word, and read-data holds that word once busy falls.
- R5: Array strobes occur only while busy. They start after relax + 1 cycles and stop relax + 1 cycles before the end, so a sense drives the read strobe for read-strobe + 1 − 2·(relax + 1) cycles. The array address stays stable throughout.
- R6: Writing program-data while the key field equals 0x3E77 programs the addressed word. The word then reads back as its old value ORed with the written data.
- R7: Writing program-data while the key field differs from 0x3E77 sets the error flag and leaves the array unchanged.
- R8: When a program completes, the key field returns to zero, and a second program without a new key is rejected as in R7.
- R9: Starting a sense or program while busy sets the error flag. The running operation completes unchanged.
- R10: An operation on a bank at or above NUM_BANKS sets the error flag, clears read-data to zero, does not raise busy and makes no array access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| fuse_addr | output | 7 | Array word address {bank, word} |
| fuse_rd_en | output | 1 | Sense strobe to the array |
| fuse_rdata | input | 32 | Array word at fuse_addr |
| fuse_pgm_en | output | 1 | Program strobe to the array |
| fuse_pgm_mask | output | 32 | Bits to burn while fuse_pgm_en is high |

## Verification
The hardest case to reach is a collision with a running operation. A second start must land in the few cycles while busy is still high, and the first operation must still finish with the right data. The stimulus gets there by issuing a read-control write on the cycle right after a sense is started. It then lets the sense run out and checks both the error flag and the sensed word. Rejected programs are checked with a sense of the same word afterwards, because the array must be shown unchanged.

// File: rtl/otp_ctl_pkg.sv
package otp_ctl_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_CSET   = 8'h04;
    localparam logic [7:0] OFS_CCLR   = 8'h08;
    localparam logic [7:0] OFS_TIMING = 8'h0C;
    localparam logic [7:0] OFS_RDCTL  = 8'h10;
    localparam logic [7:0] OFS_RDDATA = 8'h14;
    localparam logic [7:0] OFS_PGDATA = 8'h18;

    localparam int ERR_BIT  = 9;
    localparam int BUSY_BIT = 8;

    typedef struct packed {
        logic ctrl;
        logic cset;
        logic cclr;
        logic timing;
        logic rdctl;
        logic pgdata;
    } reg_hit_t;

endpackage

// File: rtl/otp_bus_decode.sv
module otp_bus_decode
    import otp_ctl_pkg::*;
(
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    output reg_hit_t   hit
);
    always_comb begin
        hit        = '0;
        hit.ctrl   = bus_wr && (bus_addr == OFS_CTRL);
        hit.cset   = bus_wr && (bus_addr == OFS_CSET);
        hit.cclr   = bus_wr && (bus_addr == OFS_CCLR);
        hit.timing = bus_wr && (bus_addr == OFS_TIMING);
        hit.rdctl  = bus_wr && (bus_addr == OFS_RDCTL);
        hit.pgdata = bus_wr && (bus_addr == OFS_PGDATA);
    end
endmodule

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
    parameter int CNT_W = 12,
    parameter int RLX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] limit,
    input  logic [RLX_W-1:0] relax_len,
    output logic             busy,
    output logic             strobe_on,
    output logic             sample,
    output logic             done
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic [RLX_W-1:0] rlx;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [EXT_W-1:0] cnt_x, lim_x, rlx_x, tail_x;

    always_comb begin
        cnt_x  = {1'b0, tmr_q.cnt};
        lim_x  = {1'b0, tmr_q.lim};
        rlx_x  = EXT_W'(tmr_q.rlx);
        tail_x = cnt_x + rlx_x;

        strobe_on = tmr_q.busy && (cnt_x >= rlx_x) && (tail_x <= lim_x);
        sample    = strobe_on && (tail_x == lim_x);
        done      = tmr_q.busy && (tmr_q.cnt == tmr_q.lim);
        busy      = tmr_q.busy;

        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (done) tmr_d.busy = 1'b0;
            else      tmr_d.cnt  = tmr_q.cnt + 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
            tmr_d.lim  = limit;
            tmr_d.rlx  = relax_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/otp_fuse_ctl.sv
module otp_fuse_ctl
    import otp_ctl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BANK_W    = 4,
    parameter int WORD_W    = 3,
    parameter int NUM_BANKS = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [BANK_W+WORD_W-1:0]  fuse_addr,
    output logic                      fuse_rd_en,
    input  logic [DATA_W-1:0]         fuse_rdata,
    output logic                      fuse_pgm_en,
    output logic [DATA_W-1:0]         fuse_pgm_mask
);
    localparam int ADDR_W = BANK_W + WORD_W;
    localparam int PG_W   = 12;
    localparam int RD_W   = 6;
    localparam int RLX_W  = 4;
    localparam logic [BANK_W:0] BANK_LIM = NUM_BANKS[BANK_W:0];

    typedef struct packed {
        logic [15:0]       key;
        logic [ADDR_W-1:0] addr;
        logic              err;
        logic [DATA_W-1:0] rd_data;
        logic [DATA_W-1:0] pg_data;
        logic              is_prog;
        logic [RLX_W-1:0]  relax;
        logic [RD_W-1:0]   rd_strobe;
        logic [PG_W-1:0]   pg_strobe;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    reg_hit_t   hit;

    logic            busy, strobe_on, tmr_sample, tmr_done;
    logic            op_start;
    logic [PG_W-1:0] tmr_limit;
    logic [RLX_W:0]  tmr_rlx;
    logic            bank_ok;
    logic [31:0]     ctrl_val;

    otp_bus_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    otp_phase_timer #(
        .CNT_W (PG_W),
        .RLX_W (RLX_W + 1)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_start),
        .limit     (tmr_limit),
        .relax_len (tmr_rlx),
        .busy      (busy),
        .strobe_on (strobe_on),
        .sample    (tmr_sample),
        .done      (tmr_done)
    );

    assign bank_ok = {1'b0, st_q.addr[ADDR_W-1:WORD_W]} < BANK_LIM;

    always_comb begin
        st_d      = st_q;
        op_start  = 1'b0;
        tmr_rlx   = {1'b0, st_q.relax} + 1'b1;
        tmr_limit = PG_W'(st_q.rd_strobe);

        if (!busy) begin
            if (hit.ctrl) begin
                st_d.key  = bus_wdata[31:16];
                st_d.addr = bus_wdata[ADDR_W-1:0];
            end
            if (hit.cset) begin
                st_d.key  = st_q.key | bus_wdata[31:16];
                st_d.addr = st_q.addr | bus_wdata[ADDR_W-1:0];
            end
            if (hit.cclr) begin
                st_d.key  = st_q.key & ~bus_wdata[31:16];
                st_d.addr = st_q.addr & ~bus_wdata[ADDR_W-1:0];
            end
            if (hit.timing) begin
                st_d.pg_strobe = bus_wdata[11:0];
                st_d.relax     = bus_wdata[15:12];
                st_d.rd_strobe = bus_wdata[21:16];
            end
        end

        if (hit.cclr && bus_wdata[ERR_BIT]) st_d.err = 1'b0;

        if (hit.rdctl && bus_wdata[0]) begin
            if (busy) begin
                st_d.err = 1'b1;
            end else if (!bank_ok) begin
                st_d.err     = 1'b1;
                st_d.rd_data = '0;
            end else begin
                op_start     = 1'b1;
                st_d.is_prog = 1'b0;
                tmr_limit    = PG_W'(st_q.rd_strobe);
            end
        end

        if (hit.pgdata) begin
            if (busy || (st_q.key != UNLOCK_KEY)) begin
                st_d.err = 1'b1;
            end else if (!bank_ok) begin
                st_d.err = 1'b1;
                st_d.key = '0;
            end else begin
                op_start     = 1'b1;
                st_d.is_prog = 1'b1;
                st_d.pg_data = bus_wdata[DATA_W-1:0];
                tmr_limit    = st_q.pg_strobe;
            end
        end

        if (tmr_sample && !st_q.is_prog) st_d.rd_data = fuse_rdata;
        if (tmr_done && st_q.is_prog)    st_d.key     = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_val                = '0;
        ctrl_val[31:16]         = st_q.key;
        ctrl_val[ERR_BIT]       = st_q.err;
        ctrl_val[BUSY_BIT]      = busy;
        ctrl_val[ADDR_W-1:0]    = st_q.addr;

        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL, OFS_CSET, OFS_CCLR: bus_rdata = ctrl_val;
            OFS_TIMING: begin
                bus_rdata[11:0]  = st_q.pg_strobe;
                bus_rdata[15:12] = st_q.relax;
                bus_rdata[21:16] = st_q.rd_strobe;
            end
            OFS_RDDATA: bus_rdata[DATA_W-1:0] = st_q.rd_data;
            default:    bus_rdata = '0;
        endcase
    end

    assign fuse_addr     = st_q.addr;
    assign fuse_rd_en    = strobe_on && !st_q.is_prog;
    assign fuse_pgm_en   = strobe_on && st_q.is_prog;
    assign fuse_pgm_mask = st_q.pg_data;

endmodule

// File: rtl/otp_fuse_ctl_chk.sv
module otp_fuse_ctl_chk #(
    parameter int BANK_W    = 4,
    parameter int WORD_W    = 3,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     op_prog,
    input logic [15:0]              key,
    input logic [BANK_W+WORD_W-1:0] fuse_addr,
    input logic                     fuse_rd_en,
    input logic                     fuse_pgm_en,
    input logic [DATA_W-1:0]        fuse_pgm_mask
);
    localparam logic [BANK_W:0] BANK_LIM = NUM_BANKS[BANK_W:0];
    logic [BANK_W:0] bank_x;
    assign bank_x = {1'b0, fuse_addr[BANK_W+WORD_W-1:WORD_W]};

    // R5: strobes only inside busy
    a_r5_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_rd_en || fuse_pgm_en) |-> busy);

    // R5: array address held during an operation
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fuse_addr));

    // R6: burn mask held across the strobe
    a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_pgm_en && $past(fuse_pgm_en)) |-> $stable(fuse_pgm_mask));

    // R7: programming only with the key in place
    a_r7_pgm_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_pgm_en |-> (key == 16'h3E77));

    // R8: key gone once a program ends
    a_r8_key_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && op_prog) |-> (key == 16'h0000));

    // R10: no access beyond the populated banks
    a_r10_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_rd_en || fuse_pgm_en) |-> (bank_x < BANK_LIM));

endmodule

bind otp_fuse_ctl otp_fuse_ctl_chk #(
    .BANK_W    (BANK_W),
    .WORD_W    (WORD_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .op_prog       (st_q.is_prog),
    .key           (st_q.key),
    .fuse_addr     (fuse_addr),
    .fuse_rd_en    (fuse_rd_en),
    .fuse_pgm_en   (fuse_pgm_en),
    .fuse_pgm_mask (fuse_pgm_mask)
);

// File: tb/otp_fuse_ctl_test.sv
module otp_fuse_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  fuse_addr;
    logic        fuse_rd_en, fuse_pgm_en;
    logic [31:0] fuse_rdata, fuse_pgm_mask;

    always #2 clk = ~clk;

    otp_fuse_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
        .fuse_rd_en(fuse_rd_en), .fuse_rdata(fuse_rdata),
        .fuse_pgm_en(fuse_pgm_en), .fuse_pgm_mask(fuse_pgm_mask)
    );

    // behavioural fuse array: bits only ever go to 1
    logic [31:0] fmem [128];
    function automatic logic [31:0] init_word(input logic [6:0] a);
        return {8'h30, 1'b0, a, 8'h0C, 1'b0, a};
    endfunction
    initial for (int i = 0; i < 128; i++) fmem[i] = init_word(7'(i));
    assign fuse_rdata = fmem[fuse_addr];
    always @(posedge clk) if (fuse_pgm_en) fmem[fuse_addr] <= fmem[fuse_addr] | fuse_pgm_mask;

    int rd_strobes = 0;
    int any_strobes = 0;
    always @(posedge clk) begin
        if (fuse_rd_en) rd_strobes++;
        if (fuse_rd_en || fuse_pgm_en) any_strobes++;
    end

    // scoreboard
    string       tag_q [$];
    logic [31:0] exp_q [$];
    logic [31:0] act_q [$];
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic post(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tag_q.push_back(tag); exp_q.push_back(exp); act_q.push_back(act);
    endtask

    initial forever begin
        @(posedge clk);
        while (exp_q.size() > 0) begin
            string t; logic [31:0] e, a;
            t = tag_q.pop_front(); e = exp_q.pop_front(); a = act_q.pop_front();
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cycles);
        logic [31:0] v;
        cycles = 0;
        forever begin
            @(negedge clk);
            bus_addr = 8'h00; #1;
            v = bus_rdata;
            if (!v[8]) break;
            cycles++;
        end
    endtask

    localparam logic [31:0] TIM = 32'h0009_1014; // relax 1, read 9, prog 20

    initial begin
        logic [31:0] v;
        int cyc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); post("R1 ctrl", v, 32'h0);
        rd(8'h0C, v); post("R1 timing", v, 32'h0);
        rd(8'h14, v); post("R1 rddata", v, 32'h0);

        // R2 timing readback
        wr(8'h0C, TIM);
        rd(8'h0C, v); post("R2 timing readback", v, TIM);

        // R3 set/clear aliases
        wr(8'h00, 32'h0000_0001);
        wr(8'h04, 32'h0000_0010);
        rd(8'h00, v); post("R3 set alias", v, 32'h0000_0011);
        wr(8'h08, 32'h0000_0001);
        rd(8'h00, v); post("R3 clear alias", v, 32'h0000_0010);

        // R4 sense bank 2 word 5, R2 busy length, R5 strobe count
        wr(8'h00, 32'h0000_0015);
        rd_strobes = 0;
        wr(8'h10, 32'h1);
        wait_idle(cyc);
        post("R2 sense busy cycles", 32'(cyc), 32'd10);
        post("R5 read strobe cycles", 32'(rd_strobes), 32'd6);
        rd(8'h14, v); post("R4 sensed word", v, init_word(7'h15));

        // R7 program without key on bank 3 word 1
        wr(8'h00, 32'h0000_0019);
        wr(8'h18, 32'hFFFF_0000);
        rd(8'h00, v); post("R7 error set, idle", v, 32'h0000_0219);
        // R3 zero write leaves error, one clears
        wr(8'h08, 32'h0000_0000);
        rd(8'h00, v); post("R3 clear with 0 keeps err", v, 32'h0000_0219);
        wr(8'h08, 32'h0000_0200);
        rd(8'h00, v); post("R3 clear err", v, 32'h0000_0019);
        wr(8'h10, 32'h1); wait_idle(cyc);
        rd(8'h14, v); post("R7 array unchanged", v, init_word(7'h19));

        // R6 program with key
        wr(8'h00, 32'h3E77_0019);
        wr(8'h18, 32'h0000_F0F0);
        wait_idle(cyc);
        post("R2 program busy cycles", 32'(cyc), 32'd21);
        rd(8'h00, v); post("R8 key cleared", v, 32'h0000_0019);
        wr(8'h10, 32'h1); wait_idle(cyc);
        rd(8'h14, v); post("R6 OR programmed", v, init_word(7'h19) | 32'h0000_F0F0);

        // R8 second program without fresh key
        wr(8'h18, 32'h0F00_0000);
        rd(8'h00, v); post("R8 reprogram rejected", v, 32'h0000_0219);
        wr(8'h08, 32'h0000_0200);
        wr(8'h10, 32'h1); wait_idle(cyc);
        rd(8'h14, v); post("R8 array unchanged", v, init_word(7'h19) | 32'h0000_F0F0);

        // R9 start while busy: collide on next cycle, first sense completes
        wr(8'h00, 32'h0000_0022);
        wr(8'h10, 32'h1);
        wr(8'h10, 32'h1);
        wait_idle(cyc);
        rd(8'h00, v); post("R9 busy collision error", v, 32'h0000_0222);
        rd(8'h14, v); post("R9 first sense intact", v, init_word(7'h22));
        wr(8'h08, 32'h0000_0200);

        // R10 bank 13 out of range
        wr(8'h00, 32'h0000_006A);
        any_strobes = 0;
        wr(8'h10, 32'h1);
        rd(8'h00, v); post("R10 error, no busy", v, 32'h0000_026A);
        rd(8'h14, v); post("R10 rddata zero", v, 32'h0);
        repeat (12) @(posedge clk);
        post("R10 no array access", 32'(any_strobes), 32'd0);

        repeat (3) @(posedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule